// File: doc/BRIEF.md
# Multi-mode GPIO pin drive controller

This block sits between the port registers of a chip and its I/O pads. For each of N pins it takes a 2-bit mode field and an output latch bit, and it produces three separate pad controls: a strong pull-down, a strong pull-up and a weak pull-up. The pad level comes back through a two-flop synchronizer and is returned as the input data vector.

There are four modes: input only, push-pull, open-drain and quasi-bidirectional. The quasi-bidirectional mode allows output and input on the same pin. When such a pin is released from low to high while the pin is still seen low, the block turns on the strong pull-up for a fixed short burst of clock cycles, which is two cycles by default. It then leaves only the weak pull-up holding the line. Software must write 1 to the latch bit before it reads a quasi-bidirectional pin.

The drive enables are decoded combinationally from the current mode and latch inputs. Only the burst timer and the synchronizer hold state.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset is released with every pin in mode 2'b11 and latch 1, there is no strong pull-up burst on any pin, even if the pad is low. The weak pull-up is on and the pull-down is off.
- R2: Mode 2'b00 (input only) turns off all three drive enables of the pin, whatever the latch value.
- R3: Mode 2'b01 (push-pull) drives the strong pull-down for latch 0 and the strong pull-up for latch 1. The weak pull-up stays off in this mode.
- R4: Mode 2'b10 (open-drain) drives the strong pull-down for latch 0. For latch 1 it enables no driver at all.
- R5: In mode 2'b11 (quasi-bidirectional) with latch 0, only the strong pull-down is enabled.
- R6: In mode 2'b11, a latch change from 0 to 1 while the synchronized pin is low enables the strong pull-up for exactly 2 cycles, starting with the cycle after the first clock edge that sees the change. The weak pull-up stays on throughout.
- R7: In mode 2'b11, a latch change from 0 to 1 while the synchronized pin is high produces no strong pull-up.
- R8: Entering mode 2'b11 from another mode with the latch at 1 and the synchronized pin low starts the same 2-cycle burst.
- R9: If the pin stays low after a burst ends, no new burst starts while the mode and the latch are unchanged.
- R10: Leaving mode 2'b11, or writing the latch to 0, removes the strong pull-up in the same cycle, even in the middle of a burst.
- R11: The pull-down is never enabled in the same cycle as either pull-up.
- R12: The input data bit equals the pad level as it was two rising clock edges earlier (two-flop synchronizer). The same synchronized value is the one used for the low-level check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2*NUM_PINS | Per-pin mode field, pin p at bits [2p+1:2p] |
| dout_i | input | NUM_PINS | Per-pin output latch |
| pad_i | input | NUM_PINS | Raw pad levels (asynchronous) |
| din_o | output | NUM_PINS | Synchronized pad levels |
| pd_en_o | output | NUM_PINS | Strong pull-down enable |
| pu_en_o | output | NUM_PINS | Strong pull-up enable |
| wpu_en_o | output | NUM_PINS | Weak pull-up enable |

## Verification
The static drive enables (R2 to R5, R10, R11) are combinational from the mode and latch inputs. The bench therefore drives those inputs on a falling edge and compares the outputs one time step later, in the same cycle. The burst (R6, R8) begins on the first rising edge that sees the arming change. The bench samples it on the next two falling edges, where the pull-up must be on, and then on a third, where it must be off. It holds the pad stable for at least three edges beforehand, so the synchronized value the check uses is settled. The input data (R12) is due two rising edges after the pad changes, and the bench compares each falling-edge sample against the pad value it drove two falling edges earlier.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_PUSH   = 2'b01,
    PM_OPEN   = 2'b10,
    PM_QUASI  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic pull_dn;
    logic pull_up;
    logic weak_up;
  } pin_drive_t;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_i;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_qb_burst.sv
module gpio_qb_burst #(
  parameter int BURST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_quasi,
  input  logic dout,
  input  logic pin_low,
  output logic burst_on
);

  localparam int CNT_W = $clog2(BURST_CYCLES + 1);
  localparam int RUN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_CYCLES);
  localparam logic [RUN_W-1:0] RUN_MAX  = {RUN_W{1'b1}};

  logic             quasi_prev_q, dout_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             released, arm, cancel;

  // A release is either a 0->1 latch edge inside quasi mode, or an
  // entry into quasi mode with the latch already at 1.
  always_comb begin
    released = is_quasi && dout && (!quasi_prev_q || !dout_prev_q);
    arm      = released && pin_low;
    cancel   = !is_quasi || !dout;
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (cancel) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (arm) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quasi_prev_q <= 1'b1;
      dout_prev_q  <= 1'b1;
    end else begin
      quasi_prev_q <= is_quasi;
      dout_prev_q  <= dout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign burst_on = (cnt_q != '0) && is_quasi && dout;

  // checker state: length of the current strong pull-up run
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (!burst_on)     run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  // R6: a burst never lasts longer than its programmed length
  p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(BURST_CYCLES));

  // R7: a burst only starts when the synchronized pin was seen low
  p_burst_needs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_q != '0) |-> $past(pin_low));

  // R9: with mode and latch steady and no burst running, none starts
  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && is_quasi && dout && quasi_prev_q && dout_prev_q)
      |=> (cnt_q == '0));

  // R10: leaving quasi mode or clearing the latch empties the timer
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_quasi || !dout) |=> (cnt_q == '0));

endmodule

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode
  import gpio_pin_pkg::*;
(
  input  pin_mode_e  mode,
  input  logic       dout,
  input  logic       burst_on,
  output pin_drive_t drive
);

  always_comb begin
    drive = '0;
    unique case (mode)
      PM_INPUT: drive = '0;
      PM_PUSH: begin
        drive.pull_dn = !dout;
        drive.pull_up = dout;
      end
      PM_OPEN: begin
        drive.pull_dn = !dout;
      end
      PM_QUASI: begin
        drive.pull_dn = !dout;
        drive.weak_up = dout;
        drive.pull_up = dout && burst_on;
      end
      default: drive = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int BURST_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0]   dout_i,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   din_o,
  output logic [NUM_PINS-1:0]   pd_en_o,
  output logic [NUM_PINS-1:0]   pu_en_o,
  output logic [NUM_PINS-1:0]   wpu_en_o
);

  localparam int MODE_W = 2;

  logic [NUM_PINS-1:0] pin_sync;

  gpio_pin_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_i),
    .sync_o  (pin_sync)
  );

  assign din_o = pin_sync;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pin_mode_e  mode;
      logic       burst_on;
      pin_drive_t drive;

      assign mode = pin_mode_e'(mode_i[MODE_W*p +: MODE_W]);

      gpio_qb_burst #(
        .BURST_CYCLES (BURST_CYCLES)
      ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_quasi (mode == PM_QUASI),
        .dout     (dout_i[p]),
        .pin_low  (!pin_sync[p]),
        .burst_on (burst_on)
      );

      gpio_drive_decode u_dec (
        .mode     (mode),
        .dout     (dout_i[p]),
        .burst_on (burst_on),
        .drive    (drive)
      );

      assign pd_en_o[p]  = drive.pull_dn;
      assign pu_en_o[p]  = drive.pull_up;
      assign wpu_en_o[p] = drive.weak_up;

      // R11: pull-down never together with a pull-up
      p_no_fight_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_en_o[p] && (pu_en_o[p] || wpu_en_o[p])));

      // R2: input-only mode leaves the pad undriven
      p_input_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_INPUT) |-> !(pd_en_o[p] || pu_en_o[p] || wpu_en_o[p]));
    end
  endgenerate

endmodule

// File: tb/gpio_pin_ctrl_bench.sv
module gpio_pin_ctrl_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2*N-1:0] mode_i;
  logic [N-1:0] dout_i, pad_i;
  logic [N-1:0] din_o, pd_en_o, pu_en_o, wpu_en_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_pin_ctrl #(.NUM_PINS(N)) u_gpio_pin_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .dout_i   (dout_i),
    .pad_i    (pad_i),
    .din_o    (din_o),
    .pd_en_o  (pd_en_o),
    .pu_en_o  (pu_en_o),
    .wpu_en_o (wpu_en_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    mode_i[2*p +: 2] = m;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] hist [0:19];
    mode_i = '1;
    dout_i = '1;
    pad_i  = '0;
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);
    #1;
    // R1: no burst after reset even though pads are low
    chk("R1 pu", pu_en_o, '0);
    chk("R1 wpu", wpu_en_o, '1);
    chk("R1 pd", pd_en_o, '0);
    wait_neg(3);
    chk("R1 pu later", pu_en_o, '0);

    // Exhaustive static sweep with pads high (no bursts possible)
    pad_i = '1;
    for (int k = 0; k < N; k++) set_mode(k, 2'b00);
    dout_i = '0;
    wait_neg(3);
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 2; d++) begin
          logic [N-1:0] e_pd, e_pu, e_wpu;
          set_mode(p, m[1:0]);
          dout_i[p] = d[0];
          wait_neg(1);
          #1;
          e_pd = '0; e_pu = '0; e_wpu = '0;
          e_pd[p]  = (m != 0) && (d == 0);
          e_pu[p]  = (m == 1) && (d == 1);
          e_wpu[p] = (m == 3) && (d == 1);
          // R2 (m=0), R3 (m=1), R4 (m=2), R5/R7 (m=3), R11 via pd vs pull-ups
          chk($sformatf("R2-5 sweep pd p%0d m%0d d%0d", p, m, d), pd_en_o, e_pd);
          chk($sformatf("R3/R7 sweep pu p%0d m%0d d%0d", p, m, d), pu_en_o, e_pu);
          chk($sformatf("R5 sweep wpu p%0d m%0d d%0d", p, m, d), wpu_en_o, e_wpu);
          chk($sformatf("R11 sweep p%0d m%0d d%0d", p, m, d), pd_en_o & (pu_en_o | wpu_en_o), '0);
        end
      end
      set_mode(p, 2'b00);
      dout_i[p] = 1'b0;
    end

    // R7: quasi release with pin high gives no burst
    set_mode(3, 2'b11);
    dout_i[3] = 1'b0;
    wait_neg(3);
    dout_i[3] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wait_neg(1);
      #1;
      chk("R7 no burst pin high", pu_en_o, '0);
    end

    // R6 and R9: burst on pin 0 with pad held low
    set_mode(0, 2'b11);
    dout_i[0] = 1'b0;
    pad_i[0]  = 1'b0;
    wait_neg(4);
    dout_i[0] = 1'b1;
    #1;
    chk("R6 before edge", pu_en_o, '0);
    wait_neg(1); #1;
    chk("R6 burst cycle1", pu_en_o, 4'b0001);
    chk("R6 weak during burst", wpu_en_o, 4'b1001);
    wait_neg(1); #1;
    chk("R6 burst cycle2", pu_en_o, 4'b0001);
    wait_neg(1); #1;
    chk("R6 burst ended", pu_en_o, '0);
    chk("R6 weak after burst", wpu_en_o, 4'b1001);
    for (int i = 0; i < 4; i++) begin
      wait_neg(1); #1;
      chk("R9 no retrigger", pu_en_o, '0);
    end

    // R8: entering quasi from open-drain with latch 1, pin 2 low
    set_mode(2, 2'b10);
    dout_i[2] = 1'b1;
    pad_i[2]  = 1'b0;
    wait_neg(4);
    set_mode(2, 2'b11);
    wait_neg(1); #1;
    chk("R8 entry burst cycle1", pu_en_o, 4'b0100);
    wait_neg(1); #1;
    chk("R8 entry burst cycle2", pu_en_o, 4'b0100);
    wait_neg(1); #1;
    chk("R8 entry burst ended", pu_en_o, '0);

    // R10: cancel by mode change, then by latch write to 0
    set_mode(1, 2'b11);
    dout_i[1] = 1'b0;
    pad_i[1]  = 1'b0;
    wait_neg(4);
    dout_i[1] = 1'b1;
    wait_neg(1); #1;
    chk("R10 burst running", pu_en_o, 4'b0010);
    set_mode(1, 2'b10);
    #1;
    chk("R10 mode change cancels pu", pu_en_o, '0);
    chk("R10 mode change no pd", pd_en_o, '0);
    wait_neg(1);
    set_mode(1, 2'b11);
    wait_neg(1); #1;
    chk("R8 re-entry burst", pu_en_o, 4'b0010);
    dout_i[1] = 1'b0;
    #1;
    chk("R10 latch 0 cancels pu", pu_en_o, '0);
    chk("R10 latch 0 pull-down", pd_en_o, 4'b0010);
    wait_neg(1); #1;
    chk("R10 stays cancelled", pu_en_o, '0);

    // R12: synchronizer latency of two rising edges
    for (int k = 0; k < 20; k++) begin
      pad_i = N'((k * 5 + 3) % 16);
      hist[k] = pad_i;
      wait_neg(1);
      if (k >= 1) begin
        #1;
        chk($sformatf("R12 din step %0d", k), din_o, hist[k-1]);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule